// File: doc/BRIEF.md
# Atomic memory operation permission and alignment gate

This block sits in front of the read-modify-write engine of a load/store unit and decides, for each atomic memory operation, whether the operation may go ahead. A request brings the virtual address, the access width (a 32-bit word or a 64-bit doubleword) and the operation. The gate asks an external translator for the physical address and waits for the answer. It then reads the physical-memory attributes of the target region from a combinational lookup that is driven from the physical address. It returns exactly one verdict: go ahead with the physical address, an address-misaligned exception, an access fault, or a translation fault passed through from the translator.

Two parameters shape the behaviour. The first chooses whether a misaligned address is reported at once, before translation, or only after the attribute checks. The second sets the largest atomicity granule that may rescue a misaligned access. A misaligned access is still atomic if it fits inside one naturally aligned granule whose attribute bit is set. A third parameter removes translation, so the physical address equals the virtual one.

Top module: `amo_perm_check`

## Requirements
- R1: Reset holds the gate in its idle state: req_ready is 1, res_valid is 0 and xl_req_valid is 0.
- R2: Each accepted request gives exactly one verdict. res_valid, res_kind and res_paddr hold steady until res_ready is seen. req_ready stays 0 from acceptance until the verdict is consumed. Verdict codes on res_kind are 0 go, 1 misaligned, 2 access fault, 3 translation fault.
- R3: While waiting for translation, xl_req_valid is 1 and xl_req_vaddr carries the request address. A response with xl_rsp_fault set yields verdict 3 and no attribute check.
- R4: An attribute level of 0 on pma_amo_lvl (no atomics) yields an access fault for every operation.
- R5: pma_amo_lvl is graded 1 swap, 2 logical, 3 arithmetic. Swap (op 0) needs level 1 or more. And, or and xor (ops 2, 3, 4) need level 2 or more. Add, max, maxu, min and minu (ops 1, 5, 6, 7, 8) need level 3. A shortfall gives verdict 2.
- R6: An aligned, permitted access gives verdict 0 with res_paddr equal to the translated address. A word is aligned when address bits [1:0] are 0; a doubleword is aligned when bits [2:0] are 0.
- R7: A misaligned, permitted access gives verdict 0 when its first and last byte addresses, each masked with the inverse of (granule bytes minus 1), are equal for a granule whose pma_gran bit is set. The bits are [0] 2 B, [1] 4 B, [2] 8 B and [3] 16 B.
- R8: With late priority, a misaligned access that no granule rescues gives verdict 1, but only after the permission checks; a permission shortfall gives verdict 2 instead.
- R9: A granule bit whose size exceeds MAX_GRAN has no effect. With MAX_GRAN of 0, no misaligned access is ever rescued.
- R10: With early priority, a misaligned address gives verdict 1 on the cycle after acceptance, whatever the attributes are.
- R11: Without translation, the gate issues no translation request. The physical address equals the virtual address, and the verdict follows two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Gate idle, request taken on this edge |
| req_vaddr | input | AW | Virtual address of the operation |
| req_dword | input | 1 | 1 for a doubleword access, 0 for a word |
| req_op | input | 4 | Operation code (0 swap, 1 add, 2 and, 3 or, 4 xor, 5 max, 6 maxu, 7 min, 8 minu) |
| xl_req_valid | output | 1 | Translation wanted |
| xl_req_vaddr | output | AW | Address to translate |
| xl_rsp_valid | input | 1 | Translation answer present |
| xl_rsp_paddr | input | AW | Translated address |
| xl_rsp_fault | input | 1 | Translation faulted |
| pma_addr | output | AW | Physical address for the attribute lookup |
| pma_amo_lvl | input | 2 | Atomic permission level of the region |
| pma_gran | input | 4 | Atomicity granule bits of the region |
| res_valid | output | 1 | Verdict present |
| res_ready | input | 1 | Verdict consumed |
| res_kind | output | 2 | Verdict code |
| res_paddr | output | AW | Physical address that goes with a go verdict |

## Verification
The assertions assume that the translator answers only while a translation is requested. They also assume that the attribute inputs are stable and already describe pma_addr in the cycle the gate samples them. The stimulus sets the attributes before each request and holds them until the verdict. It raises the translation answer for one cycle, two cycles into each request, and only while the request is present. Requests are offered only while the gate is idle.

// File: rtl/amo_pc_pkg.sv
package amo_pc_pkg;

    typedef enum logic [3:0] {
        OP_SWAP = 4'd0,
        OP_ADD  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_MAX  = 4'd5,
        OP_MAXU = 4'd6,
        OP_MIN  = 4'd7,
        OP_MINU = 4'd8
    } amo_op_e;

    typedef enum logic [1:0] {
        LVL_NONE  = 2'd0,
        LVL_SWAP  = 2'd1,
        LVL_LOGIC = 2'd2,
        LVL_ARITH = 2'd3
    } amo_lvl_e;

    typedef enum logic [1:0] {
        OUT_GO     = 2'd0,
        OUT_MISAL  = 2'd1,
        OUT_AFAULT = 2'd2,
        OUT_XFAULT = 2'd3
    } out_kind_e;

    localparam int GRAN_KINDS = 4;

    function automatic logic is_unaligned(input logic [2:0] lo, input logic dword);
        return dword ? (lo != 3'd0) : (lo[1:0] != 2'd0);
    endfunction

    function automatic logic gran_size_legal(input int g);
        return (g == 0) || (g >= 2 && g <= 4096 && (g & (g - 1)) == 0);
    endfunction

endpackage

// File: rtl/amo_perm_rule.sv
module amo_perm_rule
    import amo_pc_pkg::*;
(
    input  logic [3:0] op,
    input  logic [1:0] lvl,
    output logic       allowed
);
    logic [1:0] need;
    logic       known;

    always_comb begin
        known = 1'b1;
        case (op)
            OP_SWAP:                                 need = LVL_SWAP;
            OP_AND, OP_OR, OP_XOR:                   need = LVL_LOGIC;
            OP_ADD, OP_MAX, OP_MAXU, OP_MIN, OP_MINU: need = LVL_ARITH;
            default: begin
                need  = LVL_ARITH;
                known = 1'b0;
            end
        endcase
        allowed = known && (lvl != LVL_NONE) && (lvl >= need);
    end
endmodule

// File: rtl/amo_gran_rescue.sv
module amo_gran_rescue
    import amo_pc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_GRAN = 8
) (
    input  logic [AW-1:0]         paddr,
    input  logic                  dword,
    input  logic [GRAN_KINDS-1:0] gran_on,
    output logic                  rescued
);
    logic [AW-1:0]         last_byte;
    logic [GRAN_KINDS-1:0] hit;

    assign last_byte = paddr + (dword ? AW'(7) : AW'(3));

    for (genvar k = 0; k < GRAN_KINDS; k++) begin : g_gran
        localparam int GBYTES = 2 << k;
        if (GBYTES <= MAX_GRAN) begin : g_live
            localparam logic [AW-1:0] KEEP = ~(AW'(GBYTES) - AW'(1));
            assign hit[k] = gran_on[k] && ((paddr & KEEP) == (last_byte & KEEP));
        end else begin : g_off
            assign hit[k] = 1'b0;
        end
    end

    assign rescued = |hit;
endmodule

// File: rtl/amo_perm_check.sv
module amo_perm_check
    import amo_pc_pkg::*;
#(
    parameter int AW          = 32,
    parameter int MAX_GRAN    = 8,
    parameter bit MISAL_EARLY = 1'b0,
    parameter bit HAS_XLATE   = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_vaddr,
    input  logic                  req_dword,
    input  logic [3:0]            req_op,
    output logic                  xl_req_valid,
    output logic [AW-1:0]         xl_req_vaddr,
    input  logic                  xl_rsp_valid,
    input  logic [AW-1:0]         xl_rsp_paddr,
    input  logic                  xl_rsp_fault,
    output logic [AW-1:0]         pma_addr,
    input  logic [1:0]            pma_amo_lvl,
    input  logic [GRAN_KINDS-1:0] pma_gran,
    output logic                  res_valid,
    input  logic                  res_ready,
    output logic [1:0]            res_kind,
    output logic [AW-1:0]         res_paddr
);
    if (MISAL_EARLY && MAX_GRAN != 0) begin : g_bad_prio
        $error("early misaligned priority needs MAX_GRAN of 0");
    end
    if (!gran_size_legal(MAX_GRAN)) begin : g_bad_gran
        $error("MAX_GRAN must be 0 or a power of two from 2 to 4096");
    end

    typedef enum logic [1:0] {ST_IDLE, ST_XL, ST_PMA, ST_OUT} st_e;

    typedef struct packed {
        logic [AW-1:0] va;
        logic          dw;
        logic [3:0]    op;
    } ctx_t;

    st_e           st;
    ctx_t          ctx;
    logic [AW-1:0] paddr_q;
    out_kind_e     kind_q;

    logic perm_ok;
    logic rescued;
    logic ctx_unal;
    logic req_unal;
    logic take;
    logic pma_stage;

    amo_perm_rule u_rule (
        .op      (ctx.op),
        .lvl     (pma_amo_lvl),
        .allowed (perm_ok)
    );

    amo_gran_rescue #(.AW(AW), .MAX_GRAN(MAX_GRAN)) u_gran (
        .paddr   (paddr_q),
        .dword   (ctx.dw),
        .gran_on (pma_gran),
        .rescued (rescued)
    );

    assign ctx_unal  = is_unaligned(ctx.va[2:0], ctx.dw);
    assign req_unal  = is_unaligned(req_vaddr[2:0], req_dword);
    assign take      = req_valid && (st == ST_IDLE);
    assign pma_stage = (st == ST_PMA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ctx     <= '0;
            paddr_q <= '0;
            kind_q  <= OUT_GO;
        end else begin
            case (st)
                ST_IDLE: if (take) begin
                    ctx <= '{va: req_vaddr, dw: req_dword, op: req_op};
                    paddr_q <= req_vaddr;
                    if (MISAL_EARLY && req_unal) begin
                        kind_q <= OUT_MISAL;
                        st     <= ST_OUT;
                    end else if (HAS_XLATE) begin
                        st <= ST_XL;
                    end else begin
                        st <= ST_PMA;
                    end
                end
                ST_XL: if (xl_rsp_valid) begin
                    if (xl_rsp_fault) begin
                        kind_q <= OUT_XFAULT;
                        st     <= ST_OUT;
                    end else begin
                        paddr_q <= xl_rsp_paddr;
                        st      <= ST_PMA;
                    end
                end
                ST_PMA: begin
                    if (!perm_ok)
                        kind_q <= OUT_AFAULT;
                    else if (ctx_unal && !rescued)
                        kind_q <= OUT_MISAL;
                    else
                        kind_q <= OUT_GO;
                    st <= ST_OUT;
                end
                ST_OUT: if (res_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign xl_req_valid = HAS_XLATE && (st == ST_XL);
    assign xl_req_vaddr = ctx.va;
    assign pma_addr     = paddr_q;
    assign res_valid    = (st == ST_OUT);
    assign res_kind     = kind_q;
    assign res_paddr    = paddr_q;
endmodule

// File: rtl/amo_perm_check_sva.sv
module amo_perm_check_sva #(
    parameter int AW    = 32,
    parameter bit EARLY = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic          req_dword,
    input logic          xl_req_valid,
    input logic [AW-1:0] xl_req_vaddr,
    input logic          xl_rsp_valid,
    input logic          xl_rsp_fault,
    input logic [AW-1:0] pma_addr,
    input logic [1:0]    pma_amo_lvl,
    input logic          pma_stage,
    input logic          res_valid,
    input logic          res_ready,
    input logic [1:0]    res_kind,
    input logic [AW-1:0] res_paddr
);
    logic req_mis;
    assign req_mis = req_dword ? (req_vaddr[2:0] != 3'd0) : (req_vaddr[1:0] != 2'd0);

    // R2: a pending verdict holds until it is consumed
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_kind) && $stable(res_paddr));

    // R2: never idle while a verdict is pending
    p_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && res_valid));

    // R3: translation request held with a steady address
    p_xlhold_r3: assert property (@(posedge clk) disable iff (rst)
        xl_req_valid && !xl_rsp_valid |=> xl_req_valid && $stable(xl_req_vaddr));

    // R3: faulting translation reported as code 3
    p_xfault_r3: assert property (@(posedge clk) disable iff (rst)
        xl_req_valid && xl_rsp_valid && xl_rsp_fault |=> res_valid && res_kind == 2'd3);

    // R4: no-atomics region faults
    p_none_r4: assert property (@(posedge clk) disable iff (rst)
        pma_stage && pma_amo_lvl == 2'd0 |=> res_valid && res_kind == 2'd2);

    // R6: the verdict address is the looked-up physical address
    p_addr_r6: assert property (@(posedge clk) disable iff (rst)
        pma_stage |=> res_paddr == $past(pma_addr));

    // R10: early priority reports misalignment on the next cycle
    p_early_r10: assert property (@(posedge clk) disable iff (rst)
        EARLY && req_valid && req_ready && req_mis |=> res_valid && res_kind == 2'd1);
endmodule

bind amo_perm_check amo_perm_check_sva #(.AW(AW), .EARLY(MISAL_EARLY)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_dword    (req_dword),
    .xl_req_valid (xl_req_valid),
    .xl_req_vaddr (xl_req_vaddr),
    .xl_rsp_valid (xl_rsp_valid),
    .xl_rsp_fault (xl_rsp_fault),
    .pma_addr     (pma_addr),
    .pma_amo_lvl  (pma_amo_lvl),
    .pma_stage    (pma_stage),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_kind     (res_kind),
    .res_paddr    (res_paddr)
);

// File: tb/test_amo_perm_check.sv
`timescale 1ns/1ps
module test_amo_perm_check;
    import amo_pc_pkg::*;

    localparam logic [31:0] XOFS = 32'h4000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        rv_a = 0, rv_b = 0;
    logic [31:0] vaddr = 0;
    logic        dword = 0;
    logic [3:0]  op = 0;
    logic        xl_rsp_valid = 0;
    logic        xl_rsp_fault = 0;
    logic [1:0]  lvl = 0;
    logic [3:0]  gran = 0;
    logic        res_ready = 0;
    logic [31:0] xl_rsp_paddr;

    logic        rdy_a, xlv_a, resv_a, rdy_b, xlv_b, resv_b;
    logic [31:0] xla_a, pma_a, rpa_a, xla_b, pma_b, rpa_b;
    logic [1:0]  kind_a, kind_b;

    assign xl_rsp_paddr = xla_a ^ XOFS;

    amo_perm_check i_amo_perm_check (
        .clk(clk), .rst(rst), .req_valid(rv_a), .req_ready(rdy_a),
        .req_vaddr(vaddr), .req_dword(dword), .req_op(op),
        .xl_req_valid(xlv_a), .xl_req_vaddr(xla_a), .xl_rsp_valid(xl_rsp_valid),
        .xl_rsp_paddr(xl_rsp_paddr), .xl_rsp_fault(xl_rsp_fault),
        .pma_addr(pma_a), .pma_amo_lvl(lvl), .pma_gran(gran),
        .res_valid(resv_a), .res_ready(res_ready), .res_kind(kind_a), .res_paddr(rpa_a));

    amo_perm_check #(.MAX_GRAN(0), .MISAL_EARLY(1'b1), .HAS_XLATE(1'b0)) i_amo_perm_check_early (
        .clk(clk), .rst(rst), .req_valid(rv_b), .req_ready(rdy_b),
        .req_vaddr(vaddr), .req_dword(dword), .req_op(op),
        .xl_req_valid(xlv_b), .xl_req_vaddr(xla_b), .xl_rsp_valid(xl_rsp_valid),
        .xl_rsp_paddr(xl_rsp_paddr), .xl_rsp_fault(xl_rsp_fault),
        .pma_addr(pma_b), .pma_amo_lvl(lvl), .pma_gran(gran),
        .res_valid(resv_b), .res_ready(res_ready), .res_kind(kind_b), .res_paddr(rpa_b));

    bit          sel_b = 0;
    logic        m_rdy, m_xlv, m_resv;
    logic [31:0] m_xla, m_rpa;
    logic [1:0]  m_kind;
    assign m_rdy  = sel_b ? rdy_b  : rdy_a;
    assign m_xlv  = sel_b ? xlv_b  : xlv_a;
    assign m_resv = sel_b ? resv_b : resv_a;
    assign m_xla  = sel_b ? xla_b  : xla_a;
    assign m_rpa  = sel_b ? rpa_b  : rpa_a;
    assign m_kind = sel_b ? kind_b : kind_a;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input bit b, input logic [31:0] va, input logic dw,
                           input logic [3:0] o, input logic [1:0] l, input logic [3:0] g,
                           input logic xf, output logic [1:0] k, output logic [31:0] pa,
                           output int lat, output bit saw_xl);
        int waited;
        @(negedge clk);
        sel_b = b; vaddr = va; dword = dw; op = o; lvl = l; gran = g; xl_rsp_fault = xf;
        check(m_rdy == 1'b1, "R2", "idle before request", 32'(m_rdy), 32'd1);
        if (b) rv_b = 1'b1; else rv_a = 1'b1;
        @(negedge clk);
        rv_a = 1'b0; rv_b = 1'b0;
        lat = 1; waited = 0; saw_xl = 0;
        while (!m_resv && lat < 40) begin
            if (m_xlv) begin
                saw_xl = 1;
                if (waited == 0)
                    check(m_xla == va, "R3", "translation address", m_xla, va);
                waited++;
                if (waited == 2) xl_rsp_valid = 1'b1;
            end
            @(negedge clk);
            xl_rsp_valid = 1'b0;
            lat++;
        end
        k = m_kind; pa = m_rpa;
        repeat (2) @(negedge clk);
        check(m_resv && m_kind == k && m_rpa == pa && !m_rdy, "R2", "verdict held",
              {29'd0, m_resv, m_kind}, {29'd0, 1'b1, k});
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!m_resv && m_rdy, "R2", "verdict consumed once", {30'd0, m_resv, m_rdy}, 32'd1);
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        dw;
        logic [3:0]  op;
        logic [1:0]  lvl;
        logic [3:0]  gr;
        logic        xf;
        logic [1:0]  ek;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h100, 1'b0, OP_ADD,  2'd3, 4'b0000, 1'b0, OUT_GO},     // R6 aligned word
        '{32'h108, 1'b1, OP_SWAP, 2'd1, 4'b0000, 1'b0, OUT_GO},     // R5 swap at level 1
        '{32'h200, 1'b0, OP_ADD,  2'd2, 4'b0000, 1'b0, OUT_AFAULT}, // R5 add below arith
        '{32'h200, 1'b0, OP_XOR,  2'd2, 4'b0000, 1'b0, OUT_GO},     // R5 xor at logical
        '{32'h200, 1'b0, OP_OR,   2'd1, 4'b0000, 1'b0, OUT_AFAULT}, // R5 or at swap level
        '{32'h204, 1'b1, OP_SWAP, 2'd0, 4'b0000, 1'b0, OUT_AFAULT}, // R4 none, also misaligned
        '{32'h200, 1'b0, OP_SWAP, 2'd0, 4'b0000, 1'b0, OUT_AFAULT}, // R4 none aligned
        '{32'h201, 1'b0, OP_ADD,  2'd3, 4'b0000, 1'b0, OUT_MISAL},  // R8 no granule
        '{32'h201, 1'b0, OP_ADD,  2'd3, 4'b0010, 1'b0, OUT_MISAL},  // R7 crosses 4 B
        '{32'h201, 1'b0, OP_ADD,  2'd3, 4'b0100, 1'b0, OUT_GO},     // R7 inside 8 B
        '{32'h206, 1'b0, OP_AND,  2'd3, 4'b0100, 1'b0, OUT_MISAL},  // R7 crosses 8 B
        '{32'h206, 1'b0, OP_AND,  2'd3, 4'b1000, 1'b0, OUT_MISAL},  // R9 16 B above MAX_GRAN
        '{32'h301, 1'b0, OP_MAX,  2'd2, 4'b0100, 1'b0, OUT_AFAULT}, // R8 permission first
        '{32'h100, 1'b0, OP_ADD,  2'd3, 4'b0000, 1'b1, OUT_XFAULT}, // R3 translation fault
        '{32'h104, 1'b1, OP_MINU, 2'd3, 4'b0100, 1'b0, OUT_MISAL}   // R7 dword crosses 8 B
    };

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0]  k;
        logic [31:0] pa;
        int          lat;
        bit          sx;
        repeat (3) @(negedge clk);
        check(rdy_a && !resv_a && !xlv_a, "R1", "reset idle", {29'd0, rdy_a, resv_a, xlv_a}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        check(rdy_a && !resv_a && !xlv_a && rdy_b && !resv_b, "R1", "idle after reset",
              {29'd0, rdy_a, resv_a, xlv_a}, 32'd4);

        for (int i = 0; i < NV; i++) begin
            run_one(1'b0, VECS[i].va, VECS[i].dw, VECS[i].op, VECS[i].lvl, VECS[i].gr,
                    VECS[i].xf, k, pa, lat, sx);
            check(k == VECS[i].ek, $sformatf("vector %0d", i), "verdict", 32'(k), 32'(VECS[i].ek));
            check(sx, "R3", "translation requested", 32'(sx), 32'd1);
            if (VECS[i].ek == OUT_GO)
                check(pa == (VECS[i].va ^ XOFS), "R6", "physical address", pa, VECS[i].va ^ XOFS);
        end

        // R10: early priority beats a no-atomics region
        run_one(1'b1, 32'h201, 1'b0, OP_ADD, 2'd0, 4'b0000, 1'b0, k, pa, lat, sx);
        check(k == OUT_MISAL, "R10", "early verdict", 32'(k), 32'(OUT_MISAL));
        check(lat == 1, "R10", "early latency", 32'(lat), 32'd1);
        // R10: doubleword misaligned at word offset
        run_one(1'b1, 32'h204, 1'b1, OP_SWAP, 2'd3, 4'b1111, 1'b0, k, pa, lat, sx);
        check(k == OUT_MISAL, "R10", "dword early verdict", 32'(k), 32'(OUT_MISAL));
        // R11: no translation, address passes through
        run_one(1'b1, 32'h200, 1'b0, OP_ADD, 2'd3, 4'b0000, 1'b0, k, pa, lat, sx);
        check(k == OUT_GO && pa == 32'h200, "R11", "untranslated go", pa, 32'h200);
        check(lat == 2 && !sx, "R11", "latency and no request", {lat[30:0], sx}, 32'd4);
        // R4 on the untranslated variant
        run_one(1'b1, 32'h200, 1'b0, OP_AND, 2'd0, 4'b0000, 1'b0, k, pa, lat, sx);
        check(k == OUT_AFAULT, "R4", "untranslated none", 32'(k), 32'(OUT_AFAULT));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule